// File: doc/BRIEF.md
# Multidrop-Capable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. It has one transmit line and one receive line. Both directions take their bit timing from a single programmable divider. The frame format is set by configuration inputs: the character length (five to eight bits), the parity (none, even or odd) and the stop bits (one or two). A single-entry holding register sits in front of the transmit shifter and another sits behind the receive shifter. The host can therefore queue the next character while the current one is on the wire. It can also collect a finished character while the next one is arriving.

The receiver takes sixteen timing ticks per bit period. It samples the line once, near the centre of each bit. A start edge that is high again at that centre point is discarded as noise. Each delivered character carries a parity-error flag and a framing-error flag. A separate sticky flag reports when a character was lost because the holding register had not been read.

In multidrop mode, the parity slot carries an address marker instead, and characters are always eight bits. Marker high means an address; marker low means data. The receiver swallows every address character and compares it with the programmed node number. It passes data characters up only while the most recent address matched.

Top module: `uart9_core`

## Requirements
- R1: Every bit, start and stop included, lasts 16*(cfg_div+1) clock cycles. While a frame is on the line, tx_active stays high for exactly (number of bits in the frame)*16*(cfg_div+1) cycles.
- R2: The character length is 5+cfg_len bits and is sent LSB first. rx_data holds the received bits right-aligned, and its unused upper bits read as zero.
- R3: When cfg_two_stop is 1 the transmitter sends two stop bits; when it is 0 it sends one.
- R4: cfg_parity selects the parity: 0 for none, 1 for even, 2 for odd, and 3 behaves as none. Even parity makes the count of ones over data and parity even, and odd parity makes it odd. rx_perr is set with a character whose parity bit disagrees.
- R5: tx_wr loads the transmit holding register only when tx_hold_full is 0. That register empties at the moment its character enters the shifter. A write made while tx_hold_full is 1 is dropped and never transmitted.
- R6: rx_valid rises when a character lands in the receive holding register and stays high until rx_rd, which clears it on the next cycle.
- R7: A stop bit sampled low sets rx_ferr together with the delivered character. The receiver then waits for the line to return high before it looks for a new start bit.
- R8: A character that arrives while rx_valid is 1 and rx_rd is 0 is discarded and sets rx_overrun. rx_data keeps the older character. rx_rd clears rx_overrun.
- R9: A start bit that is high again at its mid-point is rejected, and nothing is delivered.
- R10: With cfg_nine at 1, frames carry 8 data bits and then a ninth bit in the parity slot, whatever cfg_len and cfg_parity say. The transmitter puts tx_waddr in the ninth bit, and the receiver never reports a parity error.
- R11: With cfg_nine at 1, a received frame whose ninth bit is 1 is never delivered; it sets or clears a match state according to whether its 8 bits equal cfg_node. A frame whose ninth bit is 0 is delivered only while that match state is set. The match state is clear after reset.
- R12: tx_line is high whenever tx_active is 0, and after reset both tx_line is high and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Divider minus one for the oversampling tick |
| cfg_len | input | 2 | Character length code, length = 5 + code |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_parity | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| cfg_nine | input | 1 | Multidrop address mode enable |
| cfg_node | input | 8 | Node number matched against address frames |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | 8 | Character to send |
| tx_waddr | input | 1 | Ninth-bit value sent in multidrop mode |
| tx_hold_full | output | 1 | Transmit holding register occupied |
| tx_active | output | 1 | A frame is being shifted out |
| tx_line | output | 1 | Serial transmit line, idle high |
| rx_line | input | 1 | Serial receive line, idle high |
| rx_rd | input | 1 | Read strobe that frees the receive holding register |
| rx_valid | output | 1 | Receive holding register occupied |
| rx_data | output | 8 | Received character, right-aligned |
| rx_perr | output | 1 | Parity error for the held character |
| rx_ferr | output | 1 | Framing error for the held character |
| rx_overrun | output | 1 | Sticky lost-character flag |

## Verification
The assertions assume that the configuration inputs change only while both directions are idle. A format change in mid-frame would break the bit-count and delivery relations they check. They also assume that rx_line keeps each level for at least several ticks, as a real serial line does. The stimulus follows both rules. It changes configuration only after tx_active has fallen and the previous character has been collected or checked, and it holds every driven serial bit for a full bit period. The only exception is the deliberately short start pulse used to test rejection.

// File: rtl/uart9_pkg.sv
package uart9_pkg;

   typedef enum logic [1:0] {
      PAR_NONE = 2'd0,
      PAR_EVEN = 2'd1,
      PAR_ODD  = 2'd2,
      PAR_OFF  = 2'd3
   } par_mode_e;

   typedef enum logic [2:0] {
      SER_IDLE  = 3'd0,
      SER_START = 3'd1,
      SER_DATA  = 3'd2,
      SER_PAR   = 3'd3,
      SER_STOP  = 3'd4
   } ser_state_e;

   localparam int CHAR_MAX = 8;

   // Mask for the active character bits, given the length code (length = 5 + code).
   function automatic logic [CHAR_MAX-1:0] char_mask(input logic [1:0] code);
      return 8'hFF >> (2'd3 - code);
   endfunction

   // Index of the last data bit, given the length code.
   function automatic logic [2:0] last_bit(input logic [1:0] code);
      return 3'd4 + {1'b0, code};
   endfunction

endpackage

// File: rtl/uart9_baud.sv
module uart9_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (cnt_q >= div) begin
         cnt_q <= '0;
         tick  <= 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         tick  <= 1'b0;
      end
   end

   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0 && $stable(div)) |=> !tick); // R1

endmodule

// File: rtl/uart9_tx.sv
module uart9_tx
   import uart9_pkg::*;
#(
   parameter int OSR = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic [1:0] cfg_len,
   input  logic       cfg_two_stop,
   input  par_mode_e  cfg_parity,
   input  logic       cfg_nine,
   input  logic       wr,
   input  logic [7:0] wdata,
   input  logic       waddr,
   output logic       hold_full,
   output logic       active,
   output logic       txd
);

   localparam int            CW       = $clog2(OSR);
   localparam logic [CW-1:0] CNT_LAST = CW'(OSR - 1);

   ser_state_e    state_q;
   logic [CW-1:0] cnt_q;
   logic [2:0]    bit_q;
   logic [7:0]    sh_q;
   logic          xbit_q;
   logic          stop2_q;
   logic [7:0]    hold_data_q;
   logic          hold_addr_q;

   logic [1:0] eff_code;
   logic [7:0] mask;
   logic       par_en;
   logic       extra_bit;

   always_comb begin
      eff_code  = cfg_nine ? 2'd3 : cfg_len;
      mask      = char_mask(eff_code);
      par_en    = cfg_nine || cfg_parity == PAR_EVEN || cfg_parity == PAR_ODD;
      extra_bit = cfg_nine ? hold_addr_q
                           : ((cfg_parity == PAR_ODD) ^ (^(hold_data_q & mask)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= SER_IDLE;
         cnt_q       <= '0;
         bit_q       <= '0;
         sh_q        <= '0;
         xbit_q      <= 1'b0;
         stop2_q     <= 1'b0;
         txd         <= 1'b1;
         hold_full   <= 1'b0;
         hold_data_q <= '0;
         hold_addr_q <= 1'b0;
      end else begin
         if (wr && !hold_full) begin
            hold_full   <= 1'b1;
            hold_data_q <= wdata;
            hold_addr_q <= waddr;
         end
         if (tick) begin
            if (state_q == SER_IDLE) begin
               if (hold_full) begin
                  hold_full <= 1'b0;
                  sh_q      <= hold_data_q & mask;
                  xbit_q    <= extra_bit;
                  state_q   <= SER_START;
                  cnt_q     <= '0;
                  txd       <= 1'b0;
               end
            end else if (cnt_q != CNT_LAST) begin
               cnt_q <= cnt_q + 1'b1;
            end else begin
               cnt_q <= '0;
               case (state_q)
                  SER_START: begin
                     state_q <= SER_DATA;
                     bit_q   <= '0;
                     txd     <= sh_q[0];
                  end
                  SER_DATA: begin
                     if (bit_q == last_bit(eff_code)) begin
                        stop2_q <= 1'b0;
                        if (par_en) begin
                           state_q <= SER_PAR;
                           txd     <= xbit_q;
                        end else begin
                           state_q <= SER_STOP;
                           txd     <= 1'b1;
                        end
                     end else begin
                        sh_q  <= sh_q >> 1;
                        txd   <= sh_q[1];
                        bit_q <= bit_q + 1'b1;
                     end
                  end
                  SER_PAR: begin
                     state_q <= SER_STOP;
                     stop2_q <= 1'b0;
                     txd     <= 1'b1;
                  end
                  SER_STOP: begin
                     if (cfg_two_stop && !stop2_q) stop2_q <= 1'b1;
                     else                          state_q <= SER_IDLE;
                  end
                  default: state_q <= SER_IDLE;
               endcase
            end
         end
      end
   end

   assign active = (state_q != SER_IDLE);

   AST_TX_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> txd); // R12
   AST_HOLD_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && state_q == SER_IDLE && hold_full) |=> (!hold_full && active && !txd)); // R5
   AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_full && wr && !(tick && state_q == SER_IDLE)) |=> (hold_full && $stable(hold_data_q))); // R5

endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
   import uart9_pkg::*;
#(
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rxd,
   input  logic [1:0] cfg_len,
   input  par_mode_e  cfg_parity,
   input  logic       cfg_nine,
   output logic       done,
   output logic [7:0] d_data,
   output logic       d_ninth,
   output logic       d_perr,
   output logic       d_ferr
);

   localparam int            CW       = $clog2(OSR);
   localparam logic [CW-1:0] CNT_LAST = CW'(OSR - 1);
   localparam logic [CW-1:0] CNT_MID  = CW'(OSR / 2 - 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   rxs;

   genvar g;
   generate
      for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[g] <= 1'b1;
               else        sync_q[g] <= rxd;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[g] <= 1'b1;
               else        sync_q[g] <= sync_q[g-1];
            end
         end
      end
   endgenerate

   assign rxs = sync_q[SYNC_STAGES-1];

   ser_state_e    state_q;
   logic [CW-1:0] cnt_q;
   logic [2:0]    bit_q;
   logic [7:0]    sh_q;
   logic          xbit_q;
   logic          armed_q;

   logic [1:0] eff_code;
   logic       par_en;
   logic [7:0] aligned;
   logic       par_exp;

   always_comb begin
      eff_code = cfg_nine ? 2'd3 : cfg_len;
      par_en   = cfg_nine || cfg_parity == PAR_EVEN || cfg_parity == PAR_ODD;
      aligned  = sh_q >> (2'd3 - eff_code);
      par_exp  = (cfg_parity == PAR_ODD) ^ (^aligned);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SER_IDLE;
         cnt_q   <= '0;
         bit_q   <= '0;
         sh_q    <= '0;
         xbit_q  <= 1'b0;
         armed_q <= 1'b0;
         done    <= 1'b0;
         d_data  <= '0;
         d_ninth <= 1'b0;
         d_perr  <= 1'b0;
         d_ferr  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            case (state_q)
               SER_IDLE: begin
                  if (rxs) begin
                     armed_q <= 1'b1;
                  end else if (armed_q) begin
                     armed_q <= 1'b0;
                     state_q <= SER_START;
                     cnt_q   <= '0;
                  end
               end
               SER_START: begin
                  if (cnt_q == CNT_MID) begin
                     cnt_q <= '0;
                     if (rxs) state_q <= SER_IDLE;
                     else begin
                        state_q <= SER_DATA;
                        bit_q   <= '0;
                     end
                  end else cnt_q <= cnt_q + 1'b1;
               end
               SER_DATA: begin
                  if (cnt_q == CNT_LAST) begin
                     cnt_q <= '0;
                     sh_q  <= {rxs, sh_q[7:1]};
                     if (bit_q == last_bit(eff_code))
                        state_q <= par_en ? SER_PAR : SER_STOP;
                     else
                        bit_q <= bit_q + 1'b1;
                  end else cnt_q <= cnt_q + 1'b1;
               end
               SER_PAR: begin
                  if (cnt_q == CNT_LAST) begin
                     cnt_q   <= '0;
                     xbit_q  <= rxs;
                     state_q <= SER_STOP;
                  end else cnt_q <= cnt_q + 1'b1;
               end
               SER_STOP: begin
                  if (cnt_q == CNT_LAST) begin
                     cnt_q   <= '0;
                     state_q <= SER_IDLE;
                     done    <= 1'b1;
                     d_data  <= aligned;
                     d_ninth <= cfg_nine & xbit_q;
                     d_ferr  <= !rxs;
                     d_perr  <= !cfg_nine && par_en && (xbit_q != par_exp);
                  end else cnt_q <= cnt_q + 1'b1;
               end
               default: state_q <= SER_IDLE;
            endcase
         end
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R6
   AST_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SER_START && tick && cnt_q == CNT_MID && rxs) |=> (state_q == SER_IDLE && !done)); // R9
   AST_STOP_FERR: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SER_STOP && tick && cnt_q == CNT_LAST && !rxs) |=> (done && d_ferr)); // R7
   AST_NINE_NO_PERR: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cfg_nine) |-> !d_perr); // R10

endmodule

// File: rtl/uart9_rxhold.sv
module uart9_rxhold (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       done,
   input  logic [7:0] d_data,
   input  logic       d_ninth,
   input  logic       d_perr,
   input  logic       d_ferr,
   input  logic       cfg_nine,
   input  logic [7:0] cfg_node,
   input  logic       rd,
   output logic       valid,
   output logic [7:0] data,
   output logic       perr,
   output logic       ferr,
   output logic       overrun
);

   logic matched_q;
   logic accept;

   assign accept = done && (!cfg_nine || (!d_ninth && matched_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         matched_q <= 1'b0;
         valid     <= 1'b0;
         data      <= '0;
         perr      <= 1'b0;
         ferr      <= 1'b0;
         overrun   <= 1'b0;
      end else begin
         if (done && cfg_nine && d_ninth) matched_q <= (d_data == cfg_node);
         if (accept && (!valid || rd)) begin
            valid <= 1'b1;
            data  <= d_data;
            perr  <= d_perr;
            ferr  <= d_ferr;
         end else if (rd) begin
            valid <= 1'b0;
         end
         if (accept && valid && !rd) overrun <= 1'b1;
         else if (rd)                overrun <= 1'b0;
      end
   end

   AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (done && valid && !rd && (!cfg_nine || (!d_ninth && matched_q))) |=> overrun); // R8
   AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !rd) |=> (valid && $stable(data))); // R8
   AST_ADDR_SWALLOWED: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cfg_nine && d_ninth && !valid) |=> !valid); // R11
   AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !done) |=> (!valid && !overrun)); // R6

endmodule

// File: rtl/uart9_core.sv
module uart9_core #(
   parameter int DIV_W       = 16,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic [1:0]       cfg_len,
   input  logic             cfg_two_stop,
   input  logic [1:0]       cfg_parity,
   input  logic             cfg_nine,
   input  logic [7:0]       cfg_node,
   input  logic             tx_wr,
   input  logic [7:0]       tx_wdata,
   input  logic             tx_waddr,
   output logic             tx_hold_full,
   output logic             tx_active,
   output logic             tx_line,
   input  logic             rx_line,
   input  logic             rx_rd,
   output logic             rx_valid,
   output logic [7:0]       rx_data,
   output logic             rx_perr,
   output logic             rx_ferr,
   output logic             rx_overrun
);
   import uart9_pkg::*;

   generate
      if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
         $error("uart9_core: OSR must be even and at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("uart9_core: SYNC_STAGES must be at least 2");
      end
      if (DIV_W < 1 || DIV_W > 24) begin : g_bad_div
         $error("uart9_core: DIV_W must lie in 1..24");
      end
   endgenerate

   par_mode_e  par_mode;
   logic       tick;
   logic       rx_done;
   logic [7:0] rx_d;
   logic       rx_ninth;
   logic       rx_pe;
   logic       rx_fe;

   assign par_mode = par_mode_e'(cfg_parity);

   uart9_baud #(.DIV_W(DIV_W)) baud_i (
      .clk   (clk),
      .rst_n (rst_n),
      .div   (cfg_div),
      .tick  (tick)
   );

   uart9_tx #(.OSR(OSR)) tx_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .cfg_len      (cfg_len),
      .cfg_two_stop (cfg_two_stop),
      .cfg_parity   (par_mode),
      .cfg_nine     (cfg_nine),
      .wr           (tx_wr),
      .wdata        (tx_wdata),
      .waddr        (tx_waddr),
      .hold_full    (tx_hold_full),
      .active       (tx_active),
      .txd          (tx_line)
   );

   uart9_rx #(.OSR(OSR), .SYNC_STAGES(SYNC_STAGES)) rx_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .rxd        (rx_line),
      .cfg_len    (cfg_len),
      .cfg_parity (par_mode),
      .cfg_nine   (cfg_nine),
      .done       (rx_done),
      .d_data     (rx_d),
      .d_ninth    (rx_ninth),
      .d_perr     (rx_pe),
      .d_ferr     (rx_fe)
   );

   uart9_rxhold hold_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (rx_done),
      .d_data   (rx_d),
      .d_ninth  (rx_ninth),
      .d_perr   (rx_pe),
      .d_ferr   (rx_fe),
      .cfg_nine (cfg_nine),
      .cfg_node (cfg_node),
      .rd       (rx_rd),
      .valid    (rx_valid),
      .data     (rx_data),
      .perr     (rx_perr),
      .ferr     (rx_ferr),
      .overrun  (rx_overrun)
   );

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !cfg_nine) |-> ((rx_data & ~(8'hFF >> (2'd3 - cfg_len))) == 8'h00)); // R2

endmodule

// File: tb/uart9_core_tb_top.sv
module uart9_core_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 3;
   localparam int BIT_CLKS   = 16 * (DIV + 1);

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [15:0] cfg_div = 16'(DIV);
   logic [1:0] cfg_len = 2'd3;
   logic       cfg_two_stop = 1'b0;
   logic [1:0] cfg_parity = 2'd0;
   logic       cfg_nine = 1'b0;
   logic [7:0] cfg_node = 8'h00;
   logic       tx_wr = 1'b0;
   logic [7:0] tx_wdata = 8'h00;
   logic       tx_waddr = 1'b0;
   logic       rx_rd = 1'b0;
   logic       drv_rx = 1'b1;
   logic       loop_sel = 1'b0;
   logic       tx_hold_full, tx_active, tx_line, rx_line;
   logic       rx_valid, rx_perr, rx_ferr, rx_overrun;
   logic [7:0] rx_data;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   assign rx_line = loop_sel ? tx_line : drv_rx;

   uart9_core dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_len(cfg_len),
      .cfg_two_stop(cfg_two_stop), .cfg_parity(cfg_parity), .cfg_nine(cfg_nine),
      .cfg_node(cfg_node), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_waddr(tx_waddr),
      .tx_hold_full(tx_hold_full), .tx_active(tx_active), .tx_line(tx_line),
      .rx_line(rx_line), .rx_rd(rx_rd), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_overrun(rx_overrun)
   );

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr_tx(input logic [7:0] d, input logic a);
      tx_wdata = d; tx_waddr = a; tx_wr = 1'b1;
      step(1);
      tx_wr = 1'b0;
   endtask

   task automatic rd_rx();
      rx_rd = 1'b1;
      step(1);
      rx_rd = 1'b0;
   endtask

   task automatic wait_valid(output bit got, input int lim);
      got = 1'b0;
      for (int i = 0; i < lim; i++) begin
         if (rx_valid) begin got = 1'b1; break; end
         step(1);
      end
   endtask

   task automatic measure_active(output int cyc);
      cyc = 0;
      for (int i = 0; i < 2000; i++) begin
         if (tx_active) break;
         step(1);
      end
      while (tx_active && cyc < 20000) begin
         step(1);
         cyc++;
      end
   endtask

   function automatic logic [7:0] mask_of(input int nb);
      return 8'((1 << nb) - 1);
   endfunction

   function automatic logic par_of(input logic [7:0] d, input int nb, input bit odd);
      return odd ^ (^(d & mask_of(nb)));
   endfunction

   task automatic send_raw(input logic [11:0] v, input int n);
      loop_sel = 1'b0;
      for (int i = 0; i < n; i++) begin
         drv_rx = v[i];
         step(BIT_CLKS);
      end
      drv_rx = 1'b1;
      step(2 * BIT_CLKS);
   endtask

   task automatic send_frame(input logic [7:0] d, input int nb, input bit has_x, input logic x, input logic stopv);
      logic [11:0] v;
      int n;
      v = '1; v[0] = 1'b0; n = 1;
      for (int i = 0; i < nb; i++) begin v[n] = d[i]; n++; end
      if (has_x) begin v[n] = x; n++; end
      v[n] = stopv; n++;
      send_raw(v, n);
   endtask

   task automatic lb_random();
      logic [1:0] code; logic [1:0] par; logic two; logic [7:0] d;
      int cyc, nbits; bit got;
      code = 2'($urandom % 4); par = 2'($urandom % 4); two = 1'($urandom % 2); d = 8'($urandom % 256);
      cfg_len = code; cfg_parity = par; cfg_two_stop = two; cfg_nine = 1'b0;
      loop_sel = 1'b1;
      step(2);
      wr_tx(d, 1'b0);
      measure_active(cyc);
      nbits = 1 + (5 + int'(code)) + ((par == 2'd1 || par == 2'd2) ? 1 : 0) + 1 + int'(two);
      check(cyc == nbits * BIT_CLKS, "R1", "frame length with stop count R3", cyc, nbits * BIT_CLKS);
      check(tx_line == 1'b1, "R12", "line idles high", int'(tx_line), 1);
      wait_valid(got, 100);
      check(got, "R6", "loopback character delivered", int'(got), 1);
      check(rx_data == (d & mask_of(5 + int'(code))), "R2", "loopback data", rx_data, d & mask_of(5 + int'(code)));
      check(!rx_perr, "R4", "no parity error on loopback", int'(rx_perr), 0);
      check(!rx_ferr, "R7", "no framing error on loopback", int'(rx_ferr), 0);
      rd_rx();
      check(!rx_valid, "R6", "read frees holding register", int'(rx_valid), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired: actual=%0h expected=%0h", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      bit got;
      int cyc;
      void'($urandom(32'h1A2B3C4D));
      step(3);
      rst_n = 1'b1;
      step(2);

      // Reset state
      check(tx_line == 1'b1, "R12", "reset line level", int'(tx_line), 1);
      check(!tx_active, "R12", "reset tx_active", int'(tx_active), 0);
      check(!tx_hold_full, "R5", "reset hold flag", int'(tx_hold_full), 0);
      check(!rx_valid && !rx_overrun, "R6", "reset rx flags", int'({rx_valid, rx_overrun}), 0);

      // Random loopback frames
      for (int k = 0; k < 16; k++) lb_random();

      // Transmit double buffering, write while full dropped
      cfg_len = 2'd3; cfg_parity = 2'd0; cfg_two_stop = 1'b0; loop_sel = 1'b1;
      step(2);
      wr_tx(8'hA1, 1'b0);
      check(tx_hold_full, "R5", "hold full after write", int'(tx_hold_full), 1);
      for (int i = 0; i < 200 && !tx_active; i++) step(1);
      check(!tx_hold_full && tx_active, "R5", "hold drains at frame start", int'({tx_hold_full, tx_active}), 1);
      wr_tx(8'hB2, 1'b0);
      wr_tx(8'hC3, 1'b0);
      check(tx_hold_full, "R5", "second write queued", int'(tx_hold_full), 1);
      wait_valid(got, 3000);
      check(got && rx_data == 8'hA1, "R5", "first queued character", rx_data, 8'hA1);
      rd_rx();
      wait_valid(got, 3000);
      check(got && rx_data == 8'hB2, "R5", "second queued character", rx_data, 8'hB2);
      rd_rx();
      wait_valid(got, 2500);
      check(!got && !tx_active, "R5", "write while full never sent", int'(got), 0);

      // Parity errors and good parity, bench driven
      cfg_len = 2'd3; cfg_parity = 2'd1;
      send_frame(8'h35, 8, 1'b1, ~par_of(8'h35, 8, 1'b0), 1'b1);
      check(rx_valid && rx_perr, "R4", "even parity mismatch flagged", int'(rx_perr), 1);
      check(rx_data == 8'h35, "R4", "data with parity error", rx_data, 8'h35);
      rd_rx();
      cfg_parity = 2'd2; cfg_len = 2'd1;
      send_frame(8'h2B, 6, 1'b1, par_of(8'h2B, 6, 1'b1), 1'b1);
      check(rx_valid && !rx_perr, "R4", "odd parity accepted", int'(rx_perr), 0);
      check(rx_data == 8'h2B, "R2", "six-bit character", rx_data, 8'h2B);
      rd_rx();

      // Framing error then recovery
      cfg_parity = 2'd0; cfg_len = 2'd3;
      send_frame(8'h5C, 8, 1'b0, 1'b0, 1'b0);
      check(rx_valid && rx_ferr, "R7", "low stop flagged", int'(rx_ferr), 1);
      check(rx_data == 8'h5C, "R7", "data with framing error", rx_data, 8'h5C);
      rd_rx();
      step(4 * BIT_CLKS);
      check(!rx_valid, "R7", "no spurious frame after break", int'(rx_valid), 0);
      send_frame(8'h96, 8, 1'b0, 1'b0, 1'b1);
      check(rx_valid && !rx_ferr && rx_data == 8'h96, "R7", "clean frame after error", rx_data, 8'h96);
      rd_rx();

      // False start rejected
      drv_rx = 1'b0;
      step(4 * (DIV + 1));
      drv_rx = 1'b1;
      step(12 * BIT_CLKS);
      check(!rx_valid, "R9", "short low pulse ignored", int'(rx_valid), 0);
      send_frame(8'h3E, 8, 1'b0, 1'b0, 1'b1);
      check(rx_valid && rx_data == 8'h3E, "R9", "receiver usable after glitch", rx_data, 8'h3E);
      rd_rx();

      // Overrun
      send_frame(8'h71, 8, 1'b0, 1'b0, 1'b1);
      send_frame(8'h82, 8, 1'b0, 1'b0, 1'b1);
      check(rx_overrun, "R8", "overrun flagged", int'(rx_overrun), 1);
      check(rx_data == 8'h71, "R8", "older character kept", rx_data, 8'h71);
      rd_rx();
      check(!rx_overrun && !rx_valid, "R8", "read clears overrun", int'({rx_overrun, rx_valid}), 0);

      // Address filtering, bench driven
      cfg_nine = 1'b1; cfg_node = 8'h5A; cfg_parity = 2'd2; cfg_len = 2'd0;
      send_frame(8'h11, 8, 1'b1, 1'b0, 1'b1);
      check(!rx_valid, "R11", "data before any address dropped", int'(rx_valid), 0);
      send_frame(8'h33, 8, 1'b1, 1'b1, 1'b1);
      send_frame(8'h22, 8, 1'b1, 1'b0, 1'b1);
      check(!rx_valid, "R11", "data after foreign address dropped", int'(rx_valid), 0);
      send_frame(8'h5A, 8, 1'b1, 1'b1, 1'b1);
      check(!rx_valid, "R11", "own address not delivered", int'(rx_valid), 0);
      send_frame(8'h44, 8, 1'b1, 1'b0, 1'b1);
      check(rx_valid && rx_data == 8'h44 && !rx_perr, "R11", "data after own address", rx_data, 8'h44);
      rd_rx();
      send_frame(8'h45, 8, 1'b1, 1'b0, 1'b1);
      check(rx_valid && rx_data == 8'h45, "R11", "match persists", rx_data, 8'h45);
      rd_rx();
      send_frame(8'h10, 8, 1'b1, 1'b1, 1'b1);
      send_frame(8'h66, 8, 1'b1, 1'b0, 1'b1);
      check(!rx_valid, "R11", "match cleared by other address", int'(rx_valid), 0);

      // Nine-bit transmit in loopback
      loop_sel = 1'b1;
      step(2);
      wr_tx(8'h5A, 1'b1);
      measure_active(cyc);
      check(cyc == 11 * BIT_CLKS, "R10", "nine-bit frame length", cyc, 11 * BIT_CLKS);
      step(BIT_CLKS);
      check(!rx_valid, "R10", "sent address swallowed", int'(rx_valid), 0);
      wr_tx(8'h99, 1'b0);
      measure_active(cyc);
      wait_valid(got, 100);
      check(got && rx_data == 8'h99 && !rx_perr, "R10", "nine-bit data in loopback", rx_data, 8'h99);
      rd_rx();
      cfg_nine = 1'b0;
      step(4);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule